// File: doc/BRIEF.md
# Register Indirection Field Substituter

This block sits in an instruction pipeline and implements three indirection operations. Each one forms a 9-bit register address from an index operand (D) and a base operand (S). It then overrides one field of the instruction that follows. The field is chosen by the operation:
- the source field, for the source-select operation;
- the destination field, for the destination-select operation;
- the result-write address only, for the result-select operation.

In the same cycle the block produces a write-back value for the index. The low 9 bits of the index are advanced by a signed step taken from the upper bits of the base operand. The step wraps inside 9 bits, and the upper index bits are kept.

The override is held in a one-entry pending register. That register survives stall cycles and is consumed when the following instruction issues. The substitution changes only the fields leaving this stage; the instruction word presented at the input is never altered. An immediate-extension prefix that applied to the indirection instruction is flagged as still applying to the following instruction.

Top module: `reg_indirect_subst`

## Requirements
- R1: The substituted address is (D[8:0] + S[8:0]) modulo 512, with any carry out of bit 8 discarded. For example, D=$144 and S=$144 give $088.
- R2: When `alt_op_i`=2'b01 (source-select), the next instruction's source field `src_o` carries the substituted address. `dst_o` and `res_o` both equal bits [17:9] of `next_instr_i`.
- R3: When `alt_op_i`=2'b10 (destination-select), both `dst_o` and `res_o` carry the substituted address. `src_o` equals bits [8:0] of `next_instr_i`.
- R4: When `alt_op_i`=2'b11 (result-select), only `res_o` carries the substituted address. `src_o` and `dst_o` equal bits [8:0] and [17:9] of `next_instr_i`.
- R5: While `alt_op_i` is nonzero, `wb_en_o` is 1 and the write-back value is as follows. `wb_data_o`[31:9] equals D[31:9]. `wb_data_o`[8:0] equals (D[8:0] + S[17:9]) modulo 512, where S[17:9] is a two's-complement step with S[17] as its sign. When `alt_op_i` is 2'b00, `wb_en_o` is 0.
- R6: The override registered at the clock edge where `alt_op_i` is nonzero stays in effect, with an unchanged address, through every cycle in which `issue_i` is 0. It is cleared by the first clock edge at which `issue_i` is 1.
- R7: After reset, and whenever no override is pending, `pending_o` is 0 and `src_o`, `dst_o` and `res_o` equal bits [8:0], [17:9] and [17:9] of `next_instr_i`.
- R8: `prefix_o` is 1 exactly while an override is pending whose indirection instruction had `prefix_i`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alt_op_i | input | 2 | Indirection operation in this stage: 00 none, 01 source, 10 destination, 11 result |
| prefix_i | input | 1 | An immediate-extension prefix applied to the indirection instruction |
| d_val_i | input | 32 | Index operand D |
| s_val_i | input | 32 | Base operand S |
| next_instr_i | input | 32 | Following instruction word; source field [8:0], destination field [17:9] |
| issue_i | input | 1 | The following instruction issues this cycle |
| src_o | output | 9 | Effective source field |
| dst_o | output | 9 | Effective destination field |
| res_o | output | 9 | Effective result-write address |
| wb_data_o | output | 32 | Index write-back value |
| wb_en_o | output | 1 | Index write-back enable |
| pending_o | output | 1 | An override is waiting for the following instruction |
| prefix_o | output | 1 | The prefix also applies to the following instruction |

## Verification
The assertions assume that `issue_i` refers only to the instruction that follows a pending indirection. They also assume that `alt_op_i` is nonzero only in a cycle where an indirection instruction actually executes. The stimulus drives every indirection with `issue_i` held at 0, then selects the following instruction with `alt_op_i` at 00. It lowers `issue_i` only to model stalls, and never starts a new indirection while one is pending and stalled.

// File: rtl/ria_pkg.sv
package ria_pkg;
  typedef enum logic [1:0] {
    ALT_NONE = 2'b00,
    ALT_SRC  = 2'b01,
    ALT_DST  = 2'b10,
    ALT_RES  = 2'b11
  } alt_op_e;
endpackage

// File: rtl/ria_addr_calc.sv
module ria_addr_calc #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 9
) (
  input  logic [DATA_W-1:0] idx_i,
  input  logic [DATA_W-1:0] base_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] idx_wb_o
);
  localparam int STEP_LSB = ADDR_W;
  localparam int STEP_MSB = 2*ADDR_W - 1;

  logic [ADDR_W-1:0] idx_lo;
  logic [ADDR_W-1:0] step;

  assign idx_lo = idx_i[ADDR_W-1:0];
  assign step   = base_i[STEP_MSB:STEP_LSB];

  // modulo-2^ADDR_W adds; carries are dropped on purpose
  assign addr_o   = idx_lo + base_i[ADDR_W-1:0];
  assign idx_wb_o = {idx_i[DATA_W-1:ADDR_W], idx_lo + step};
endmodule

// File: rtl/ria_pending.sv
module ria_pending
  import ria_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  alt_op_e           op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              prefix_i,
  input  logic              issue_i,
  output logic              pend_o,
  output alt_op_e           kind_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              prefix_o
);
  logic              pend_q;
  alt_op_e           kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic              prefix_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= 1'b0;
      kind_q   <= ALT_NONE;
      addr_q   <= '0;
      prefix_q <= 1'b0;
    end else if (op_i != ALT_NONE) begin
      pend_q   <= 1'b1;
      kind_q   <= op_i;
      addr_q   <= addr_i;
      prefix_q <= prefix_i;
    end else if (pend_q && issue_i) begin
      pend_q   <= 1'b0;
      prefix_q <= 1'b0;
    end
  end

  assign pend_o   = pend_q;
  assign kind_o   = kind_q;
  assign addr_o   = addr_q;
  assign prefix_o = pend_q & prefix_q;

  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !issue_i && op_i == ALT_NONE) |=> (pend_q && $stable(addr_q) && $stable(kind_q)));

  assert_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && issue_i && op_i == ALT_NONE) |=> !pend_q);

  assert_load_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i != ALT_NONE) |=> (pend_q && addr_q == $past(addr_i)));
endmodule

// File: rtl/ria_field_mux.sv
module ria_field_mux
  import ria_pkg::*;
#(
  parameter int INSTR_W = 32,
  parameter int ADDR_W  = 9
) (
  input  logic               pend_i,
  input  alt_op_e            kind_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [INSTR_W-1:0] instr_i,
  output logic [ADDR_W-1:0]  src_o,
  output logic [ADDR_W-1:0]  dst_o,
  output logic [ADDR_W-1:0]  res_o
);
  localparam int SRC_LSB = 0;
  localparam int DST_LSB = ADDR_W;

  logic [ADDR_W-1:0] raw_src;
  logic [ADDR_W-1:0] raw_dst;

  assign raw_src = instr_i[SRC_LSB +: ADDR_W];
  assign raw_dst = instr_i[DST_LSB +: ADDR_W];

  always_comb begin
    src_o = raw_src;
    dst_o = raw_dst;
    if (pend_i && kind_i == ALT_SRC) src_o = addr_i;
    if (pend_i && kind_i == ALT_DST) dst_o = addr_i;
    // result address follows the (possibly substituted) destination
    res_o = (pend_i && kind_i == ALT_RES) ? addr_i : dst_o;
  end
endmodule

// File: rtl/reg_indirect_subst.sv
module reg_indirect_subst
  import ria_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int INSTR_W = 32,
  parameter int ADDR_W  = 9
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         alt_op_i,
  input  logic               prefix_i,
  input  logic [DATA_W-1:0]  d_val_i,
  input  logic [DATA_W-1:0]  s_val_i,
  input  logic [INSTR_W-1:0] next_instr_i,
  input  logic               issue_i,
  output logic [ADDR_W-1:0]  src_o,
  output logic [ADDR_W-1:0]  dst_o,
  output logic [ADDR_W-1:0]  res_o,
  output logic [DATA_W-1:0]  wb_data_o,
  output logic               wb_en_o,
  output logic               pending_o,
  output logic               prefix_o
);
  localparam int DST_LSB = ADDR_W;

  alt_op_e           op;
  alt_op_e           kind;
  logic [ADDR_W-1:0] calc_addr;
  logic [ADDR_W-1:0] held_addr;

  assign op = alt_op_e'(alt_op_i);

  ria_addr_calc #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_calc (
    .idx_i   (d_val_i),
    .base_i  (s_val_i),
    .addr_o  (calc_addr),
    .idx_wb_o(wb_data_o)
  );

  ria_pending #(.ADDR_W(ADDR_W)) u_pend (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .op_i    (op),
    .addr_i  (calc_addr),
    .prefix_i(prefix_i),
    .issue_i (issue_i),
    .pend_o  (pending_o),
    .kind_o  (kind),
    .addr_o  (held_addr),
    .prefix_o(prefix_o)
  );

  ria_field_mux #(.INSTR_W(INSTR_W), .ADDR_W(ADDR_W)) u_mux (
    .pend_i (pending_o),
    .kind_i (kind),
    .addr_i (held_addr),
    .instr_i(next_instr_i),
    .src_o  (src_o),
    .dst_o  (dst_o),
    .res_o  (res_o)
  );

  assign wb_en_o = (op != ALT_NONE);

  assert_wb_upper_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> wb_data_o[DATA_W-1:ADDR_W] == d_val_i[DATA_W-1:ADDR_W]);

  assert_src_only_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_o && kind == ALT_SRC) |-> (dst_o == next_instr_i[DST_LSB +: ADDR_W] && res_o == dst_o));

  assert_res_follows_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_o && kind == ALT_DST) |-> (res_o == dst_o && src_o == next_instr_i[ADDR_W-1:0]));

  assert_res_only_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_o && kind == ALT_RES) |-> (dst_o == next_instr_i[DST_LSB +: ADDR_W]));

  assert_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pending_o |-> (src_o == next_instr_i[ADDR_W-1:0] && res_o == dst_o && !prefix_o));
endmodule

// File: tb/reg_indirect_subst_test.sv
module reg_indirect_subst_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  alt_op = 2'b00;
  logic        prefix = 1'b0;
  logic [31:0] d_val = '0;
  logic [31:0] s_val = '0;
  logic [31:0] instr = '0;
  logic        issue = 1'b0;
  logic [8:0]  src, dst, res;
  logic [31:0] wb_data;
  logic        wb_en, pending, pfx_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  reg_indirect_subst uut (
    .clk_i(clk), .rst_ni(rst_n), .alt_op_i(alt_op), .prefix_i(prefix),
    .d_val_i(d_val), .s_val_i(s_val), .next_instr_i(instr), .issue_i(issue),
    .src_o(src), .dst_o(dst), .res_o(res), .wb_data_o(wb_data),
    .wb_en_o(wb_en), .pending_o(pending), .prefix_o(pfx_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // execute one indirection, check write-back, then present the next word with no issue
  task automatic run_alt(input logic [1:0] op, input logic [31:0] d, input logic [31:0] s,
                         input logic pf, input logic [31:0] word, input logic [31:0] exp_wb);
    @(negedge clk);
    alt_op = op; d_val = d; s_val = s; prefix = pf; issue = 1'b0;
    #1;
    chk("R5 wb_en", {31'd0, wb_en}, 32'd1);
    chk("R5 wb_data", wb_data, exp_wb);
    @(negedge clk);
    alt_op = 2'b00; prefix = 1'b0; instr = word;
    #1;
    chk("R6 pending set", {31'd0, pending}, 32'd1);
    chk("R5 wb_en idle", {31'd0, wb_en}, 32'd0);
  endtask

  task automatic consume;
    issue = 1'b1;
    @(negedge clk);
    issue = 1'b0;
    #1;
    chk("R6 cleared", {31'd0, pending}, 32'd0);
  endtask

  task automatic t_reset;
    instr = 32'h0002_C0A5;
    #1;
    chk("R7 reset pending", {31'd0, pending}, 32'd0);
    chk("R7 src pass", {23'd0, src}, {23'd0, instr[8:0]});
    chk("R7 dst pass", {23'd0, dst}, {23'd0, instr[17:9]});
    chk("R7 res pass", {23'd0, res}, {23'd0, instr[17:9]});
    chk("R8 prefix idle", {31'd0, pfx_out}, 32'd0);
  endtask

  task automatic t_src;
    logic [31:0] w = 32'hDEAD_B0EF;
    run_alt(2'b01, 32'h0000_0144, 32'h0000_0144, 1'b0, w, 32'h0000_0144);
    chk("R1 R2 src wrap", {23'd0, src}, 32'h088);
    chk("R2 dst kept", {23'd0, dst}, {23'd0, w[17:9]});
    chk("R2 res kept", {23'd0, res}, {23'd0, w[17:9]});
    consume();
    chk("R7 src after", {23'd0, src}, {23'd0, w[8:0]});
  endtask

  task automatic t_steps;
    run_alt(2'b01, 32'h0000_0144, 32'h0000_0244, 1'b0, 32'h0, 32'h0000_0145);
    chk("R1 src +1 case", {23'd0, src}, 32'h188);
    consume();
    run_alt(2'b01, 32'h0000_0144, 32'h0000_0444, 1'b0, 32'h0, 32'h0000_0146);
    consume();
    run_alt(2'b01, 32'h0000_0144, 32'h0000_0844, 1'b0, 32'h0, 32'h0000_0148);
    consume();
    // step -16 from 5 wraps to $1F5, upper index bits kept
    run_alt(2'b01, 32'hFFFF_F005, {14'd0, 9'h1F0, 9'h010}, 1'b0, 32'h0, 32'hFFFF_F1F5);
    chk("R1 src small", {23'd0, src}, 32'h015);
    consume();
    // +1 from $1FF wraps to 0 without touching bit 9
    run_alt(2'b10, 32'hA5A5_A3FF, {14'd0, 9'h001, 9'h001}, 1'b0, 32'h0, 32'hA5A5_A200);
    consume();
  endtask

  task automatic t_dst;
    logic [31:0] w = 32'h1234_5678;
    run_alt(2'b10, 32'h0000_0010, 32'h0000_0020, 1'b0, w, 32'h0000_0010);
    chk("R3 dst sub", {23'd0, dst}, 32'h030);
    chk("R3 res follows", {23'd0, res}, 32'h030);
    chk("R3 src kept", {23'd0, src}, {23'd0, w[8:0]});
    consume();
  endtask

  task automatic t_res;
    logic [31:0] w = 32'h0F0F_3C3C;
    run_alt(2'b11, 32'h0000_0101, 32'h0000_0011, 1'b0, w, 32'h0000_0101);
    chk("R4 res sub", {23'd0, res}, 32'h112);
    chk("R4 dst kept", {23'd0, dst}, {23'd0, w[17:9]});
    chk("R4 src kept", {23'd0, src}, {23'd0, w[8:0]});
    consume();
    chk("R7 res after", {23'd0, res}, {23'd0, w[17:9]});
  endtask

  task automatic t_stall;
    run_alt(2'b01, 32'h0000_0003, 32'h0000_0004, 1'b0, 32'h0000_0000, 32'h0000_0003);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      instr = 32'h0000_01FF ^ i;
      #1;
      chk("R6 held pending", {31'd0, pending}, 32'd1);
      chk("R6 held addr", {23'd0, src}, 32'h007);
    end
    consume();
  endtask

  task automatic t_prefix;
    run_alt(2'b10, 32'h0, 32'h0000_0005, 1'b1, 32'h0, 32'h0);
    chk("R8 prefix leak", {31'd0, pfx_out}, 32'd1);
    consume();
    chk("R8 prefix gone", {31'd0, pfx_out}, 32'd0);
    run_alt(2'b10, 32'h0, 32'h0000_0005, 1'b0, 32'h0, 32'h0);
    chk("R8 no prefix", {31'd0, pfx_out}, 32'd0);
    consume();
  endtask

  initial begin
    #(4 * 50000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #1;
    t_reset();
    #9 rst_n = 1'b1;
    t_reset();
    t_src();
    t_steps();
    t_dst();
    t_res();
    t_stall();
    t_prefix();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule